// File: doc/BRIEF.md
# I2C Register-Addressed Transaction Controller

This block runs complete memory-style I2C transactions on top of a byte-level bus engine. A request names one of three operations (probe, register read, register write), a 7-bit device address, a register address of zero to `MAX_ALEN` bytes and a byte count. The controller breaks the request into a series of START, STOP, byte-write and byte-read commands for the engine. It checks each acknowledge that comes back and ends every transaction with a one-cycle completion pulse that carries the status.

Read data leaves on a valid/ready output stream and write data arrives on a valid/ready input stream. Two configuration inputs change how the bus is used. One chooses how a read turns the bus around after its pointer phase: either a bare repeated START, or a STOP followed by a START. The other folds register-address bits that lie above the requested address length into the low bits of the device address, through a mask. This serves EEPROMs that carry extra address bits in the device-address field.

On a write, a NACK on a data byte does not stop the transfer. Such NACKs are counted, and the count is returned with the completion pulse. A NACK on the device address or on a register-address byte ends the transaction at once: the controller issues STOP and flags an abort.

Top module: `i2c_xact_ctrl`

## Requirements
- R1: Engine commands use op codes START=0, STOP=1, WRITE=2, READ=3. At most one command is outstanding: after `cmd_valid`&`cmd_ready`, no new command is offered until `rsp_valid` returns. An offered command holds its op and data until it is accepted.
- R2: A probe (kind 0) issues START, WRITE of {dev,0}, STOP. `done_abort` is 0 when the address byte was acknowledged (device present) and 1 when it was NACKed.
- R3: A write (kind 2) issues START, WRITE {dev,0}, then exactly `req_alen` register-address bytes with the most significant byte first, then `req_len` bytes taken in order from the write stream, then STOP.
- R4: A read (kind 1) with nonzero address length and `cfg_rep_start`=0 issues START, WRITE {dev,0}, the address bytes, STOP, START, WRITE {dev,1}, the READ commands, then STOP.
- R5: With `cfg_rep_start`=1, the same read omits the STOP between the address bytes and the second START.
- R6: A read with `req_alen`=0 skips the pointer phase: START, WRITE {dev,1}, the READ commands, STOP.
- R7: Every READ command carries `cmd_nack`=0, except the last one of the transaction, which carries 1. The bytes returned by the engine leave on the read stream in order.
- R8: A NACK on the write-direction device address is followed only by STOP, and the transaction completes with `done_abort`=1.
- R9: A NACK on any register-address byte is followed only by STOP, and the transaction completes with `done_abort`=1.
- R10: The acknowledge on the read-direction device address is ignored. The data phase proceeds and `done_abort` stays 0.
- R11: When `cfg_fold_en`=1 for a read or write, the device address sent is dev | ((addr >> 8*alen) & `cfg_fold_mask`), keeping the low 7 bits of the shifted address.
- R12: On a write, `done_nacks` equals the number of NACKed data bytes and `done_abort` is 0. `done` is a single-cycle pulse, and `req_ready` is high only while the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_rep_start | input | 1 | 1: repeated START on read turnaround; 0: STOP then START |
| cfg_fold_en | input | 1 | Enable folding of upper address bits into the device address |
| cfg_fold_mask | input | 7 | Mask applied to the folded bits |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted (idle) |
| req_kind | input | 2 | 0 probe, 1 read, 2 write (3 acts as probe) |
| req_dev | input | 7 | Device address |
| req_addr | input | 8*MAX_ALEN | Register address |
| req_alen | input | clog2(MAX_ALEN+1) | Register address length in bytes |
| req_len | input | LEN_W | Data byte count |
| wr_valid | input | 1 | Write stream valid |
| wr_ready | output | 1 | Write stream ready |
| wr_data | input | 8 | Write stream byte |
| rd_valid | output | 1 | Read stream valid |
| rd_ready | input | 1 | Read stream ready |
| rd_data | output | 8 | Read stream byte |
| cmd_valid | output | 1 | Engine command valid |
| cmd_ready | input | 1 | Engine accepts command |
| cmd_op | output | 2 | Engine command op code |
| cmd_data | output | 8 | Byte to write |
| cmd_nack | output | 1 | For READ: send NACK after the byte |
| rsp_valid | input | 1 | Engine finished the outstanding command |
| rsp_nack | input | 1 | For WRITE: the byte was not acknowledged |
| rsp_data | input | 8 | For READ: byte received |
| done | output | 1 | Transaction complete pulse |
| done_abort | output | 1 | Address phase NACK (probe: device absent) |
| done_nacks | output | LEN_W | Count of NACKed write data bytes |

## Verification
The assertions assume that the engine raises `rsp_valid` only while a command is outstanding, and for exactly one cycle per command. They also assume that the write stream keeps `wr_valid` and `wr_data` steady until `wr_ready` takes the byte, because that byte is handed straight to the engine. The bench engine model answers each accepted command once, two cycles later. The bench holds `wr_valid` high and changes `wr_data` only after a transfer, and it toggles `cmd_ready` and `rd_ready` in fixed patterns so that stalls occur on both streams.

// File: rtl/i2c_xact_pkg.sv
package i2c_xact_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } bus_op_e;

  typedef enum logic [1:0] {
    K_PROBE = 2'd0,
    K_READ  = 2'd1,
    K_WRITE = 2'd2,
    K_RSVD  = 2'd3
  } xact_kind_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_START,
    S_DEVW,
    S_ADDR,
    S_MIDSTOP,
    S_RESTART,
    S_DEVR,
    S_RDATA,
    S_RPUSH,
    S_WDATA,
    S_STOP,
    S_DONE
  } seq_state_e;

endpackage

// File: rtl/xact_rst_sync.sv
module xact_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;
endmodule

// File: rtl/xact_fold.sv
module xact_fold
  import i2c_xact_pkg::*;
#(
  parameter int MAX_ALEN = 4,
  parameter int ALW      = $clog2(MAX_ALEN + 1)
) (
  input  logic [1:0]            kind,
  input  logic [6:0]            dev,
  input  logic [8*MAX_ALEN-1:0] addr,
  input  logic [ALW-1:0]        alen,
  input  logic                  fold_en,
  input  logic [6:0]            fold_mask,
  output logic [6:0]            dev_eff
);
  localparam int AW = 8 * MAX_ALEN;

  // hi_bits[g]: the 7 address bits just above the lowest g bytes
  logic [MAX_ALEN:0][6:0] hi_bits;

  for (genvar g = 0; g <= MAX_ALEN; g++) begin : g_hi
    if (g < MAX_ALEN) begin : g_part
      logic [AW-1:0] shifted;
      assign shifted    = addr >> (8 * g);
      assign hi_bits[g] = shifted[6:0];
    end else begin : g_none
      assign hi_bits[g] = 7'd0;
    end
  end

  logic [6:0] sel_bits;
  logic       applies;

  always_comb begin
    sel_bits = 7'd0;
    if (int'(alen) <= MAX_ALEN) sel_bits = hi_bits[alen];
  end

  assign applies = fold_en && ((kind == K_READ) || (kind == K_WRITE));
  assign dev_eff = dev | (applies ? (sel_bits & fold_mask) : 7'd0);
endmodule

// File: rtl/xact_fail_cnt.sv
module xact_fail_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign cnt_en = clr || (inc && (cnt_q != {W{1'b1}}));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R12: without a clear, the count only stays or moves up by one
  p_fail_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/xact_seq.sv
module xact_seq
  import i2c_xact_pkg::*;
#(
  parameter int MAX_ALEN = 4,
  parameter int LEN_W    = 8,
  parameter int ALW      = $clog2(MAX_ALEN + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_rep_start,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [1:0]            req_kind,
  input  logic [6:0]            req_dev_eff,
  input  logic [8*MAX_ALEN-1:0] req_addr,
  input  logic [ALW-1:0]        req_alen,
  input  logic [LEN_W-1:0]      req_len,
  input  logic                  wr_valid,
  output logic                  wr_ready,
  input  logic [7:0]            wr_data,
  output logic                  rd_valid,
  input  logic                  rd_ready,
  output logic [7:0]            rd_data,
  output logic                  cmd_valid,
  input  logic                  cmd_ready,
  output logic [1:0]            cmd_op,
  output logic [7:0]            cmd_data,
  output logic                  cmd_nack,
  input  logic                  rsp_valid,
  input  logic                  rsp_nack,
  input  logic [7:0]            rsp_data,
  output logic                  done,
  output logic                  done_abort,
  output logic                  fail_clr,
  output logic                  fail_inc
);
  localparam int IDXW = (MAX_ALEN > 1) ? $clog2(MAX_ALEN) : 1;

  seq_state_e               state_q, state_d;
  logic                     wait_q, wait_d;
  xact_kind_e               kind_q, kind_d;
  logic [6:0]               dev_q, dev_d;
  logic [MAX_ALEN-1:0][7:0] addr_q, addr_d;
  logic [ALW-1:0]           alen_q, alen_d;
  logic [IDXW-1:0]          idx_q, idx_d;
  logic [LEN_W-1:0]         remain_q, remain_d;
  logic                     rep_q, rep_d;
  logic                     abort_q, abort_d;
  logic [7:0]               rdata_q, rdata_d;
  bus_op_e                  op;
  logic                     issue;
  logic                     rsp_hit;

  assign issue   = !wait_q;
  assign rsp_hit = rsp_valid && wait_q;

  always_comb begin
    state_d   = state_q;
    wait_d    = wait_q;
    kind_d    = kind_q;
    dev_d     = dev_q;
    addr_d    = addr_q;
    alen_d    = alen_q;
    idx_d     = idx_q;
    remain_d  = remain_q;
    rep_d     = rep_q;
    abort_d   = abort_q;
    rdata_d   = rdata_q;
    req_ready = 1'b0;
    wr_ready  = 1'b0;
    rd_valid  = 1'b0;
    cmd_valid = 1'b0;
    op        = OP_START;
    cmd_data  = 8'd0;
    cmd_nack  = 1'b0;
    done      = 1'b0;
    fail_clr  = 1'b0;
    fail_inc  = 1'b0;

    unique case (state_q)
      S_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          kind_d   = xact_kind_e'(req_kind);
          dev_d    = req_dev_eff;
          addr_d   = req_addr;
          alen_d   = req_alen;
          remain_d = req_len;
          rep_d    = cfg_rep_start;
          abort_d  = 1'b0;
          fail_clr = 1'b1;
          state_d  = S_START;
        end
      end
      S_START: begin
        cmd_valid = issue;
        op        = OP_START;
        if (rsp_hit)
          state_d = (kind_q == K_READ && alen_q == '0) ? S_DEVR : S_DEVW;
      end
      S_DEVW: begin
        cmd_valid = issue;
        op        = OP_WRITE;
        cmd_data  = {dev_q, 1'b0};
        if (rsp_hit) begin
          if (rsp_nack) begin
            abort_d = 1'b1;
            state_d = S_STOP;
          end else if (kind_q != K_READ && kind_q != K_WRITE) begin
            state_d = S_STOP;
          end else if (alen_q != '0) begin
            idx_d   = IDXW'(alen_q - 1'b1);
            state_d = S_ADDR;
          end else begin
            state_d = (remain_q == '0) ? S_STOP : S_WDATA;
          end
        end
      end
      S_ADDR: begin
        cmd_valid = issue;
        op        = OP_WRITE;
        cmd_data  = addr_q[idx_q];
        if (rsp_hit) begin
          if (rsp_nack) begin
            abort_d = 1'b1;
            state_d = S_STOP;
          end else if (idx_q != '0) begin
            idx_d = idx_q - 1'b1;
          end else if (kind_q == K_READ) begin
            state_d = rep_q ? S_RESTART : S_MIDSTOP;
          end else begin
            state_d = (remain_q == '0) ? S_STOP : S_WDATA;
          end
        end
      end
      S_MIDSTOP: begin
        cmd_valid = issue;
        op        = OP_STOP;
        if (rsp_hit) state_d = S_RESTART;
      end
      S_RESTART: begin
        cmd_valid = issue;
        op        = OP_START;
        if (rsp_hit) state_d = S_DEVR;
      end
      S_DEVR: begin
        cmd_valid = issue;
        op        = OP_WRITE;
        cmd_data  = {dev_q, 1'b1};
        if (rsp_hit) state_d = (remain_q == '0) ? S_STOP : S_RDATA;
      end
      S_RDATA: begin
        cmd_valid = issue;
        op        = OP_READ;
        cmd_nack  = (remain_q == LEN_W'(1));
        if (rsp_hit) begin
          rdata_d = rsp_data;
          state_d = S_RPUSH;
        end
      end
      S_RPUSH: begin
        rd_valid = 1'b1;
        if (rd_ready) begin
          remain_d = remain_q - 1'b1;
          state_d  = (remain_q == LEN_W'(1)) ? S_STOP : S_RDATA;
        end
      end
      S_WDATA: begin
        cmd_valid = issue && wr_valid;
        wr_ready  = issue && cmd_ready;
        op        = OP_WRITE;
        cmd_data  = wr_data;
        if (rsp_hit) begin
          fail_inc = rsp_nack;
          remain_d = remain_q - 1'b1;
          state_d  = (remain_q == LEN_W'(1)) ? S_STOP : S_WDATA;
        end
      end
      S_STOP: begin
        cmd_valid = issue;
        op        = OP_STOP;
        if (rsp_hit) state_d = S_DONE;
      end
      S_DONE: begin
        done    = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase

    if (cmd_valid && cmd_ready) wait_d = 1'b1;
    else if (rsp_hit)           wait_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      wait_q   <= 1'b0;
      kind_q   <= K_PROBE;
      dev_q    <= '0;
      addr_q   <= '0;
      alen_q   <= '0;
      idx_q    <= '0;
      remain_q <= '0;
      rep_q    <= 1'b0;
      abort_q  <= 1'b0;
      rdata_q  <= '0;
    end else begin
      state_q  <= state_d;
      wait_q   <= wait_d;
      kind_q   <= kind_d;
      dev_q    <= dev_d;
      addr_q   <= addr_d;
      alen_q   <= alen_d;
      idx_q    <= idx_d;
      remain_q <= remain_d;
      rep_q    <= rep_d;
      abort_q  <= abort_d;
      rdata_q  <= rdata_d;
    end
  end

  assign cmd_op     = op;
  assign rd_data    = rdata_q;
  assign done_abort = abort_q;

  // R1: an accepted command leaves nothing new on offer until its response
  p_one_outstanding_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_valid);

  // R1: an offered command is held until taken
  p_cmd_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_data));

  // R7: read stream byte held while stalled
  p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  // R12: completion lasts one cycle and returns to idle
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);

  // R12: an accepted request makes the controller busy
  p_busy_after_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
endmodule

// File: rtl/i2c_xact_ctrl.sv
module i2c_xact_ctrl #(
  parameter int MAX_ALEN = 4,
  parameter int LEN_W    = 8,
  localparam int AW      = 8 * MAX_ALEN,
  localparam int ALW     = $clog2(MAX_ALEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_rep_start,
  input  logic             cfg_fold_en,
  input  logic [6:0]       cfg_fold_mask,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_kind,
  input  logic [6:0]       req_dev,
  input  logic [AW-1:0]    req_addr,
  input  logic [ALW-1:0]   req_alen,
  input  logic [LEN_W-1:0] req_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [1:0]       cmd_op,
  output logic [7:0]       cmd_data,
  output logic             cmd_nack,
  input  logic             rsp_valid,
  input  logic             rsp_nack,
  input  logic [7:0]       rsp_data,
  output logic             done,
  output logic             done_abort,
  output logic [LEN_W-1:0] done_nacks
);
  logic       srst_n;
  logic [6:0] dev_eff;
  logic       fail_clr;
  logic       fail_inc;

  xact_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  xact_fold #(.MAX_ALEN(MAX_ALEN), .ALW(ALW)) u_fold (
    .kind      (req_kind),
    .dev       (req_dev),
    .addr      (req_addr),
    .alen      (req_alen),
    .fold_en   (cfg_fold_en),
    .fold_mask (cfg_fold_mask),
    .dev_eff   (dev_eff)
  );

  xact_seq #(.MAX_ALEN(MAX_ALEN), .LEN_W(LEN_W), .ALW(ALW)) u_seq (
    .clk           (clk),
    .rst_n         (srst_n),
    .cfg_rep_start (cfg_rep_start),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_kind      (req_kind),
    .req_dev_eff   (dev_eff),
    .req_addr      (req_addr),
    .req_alen      (req_alen),
    .req_len       (req_len),
    .wr_valid      (wr_valid),
    .wr_ready      (wr_ready),
    .wr_data       (wr_data),
    .rd_valid      (rd_valid),
    .rd_ready      (rd_ready),
    .rd_data       (rd_data),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_op        (cmd_op),
    .cmd_data      (cmd_data),
    .cmd_nack      (cmd_nack),
    .rsp_valid     (rsp_valid),
    .rsp_nack      (rsp_nack),
    .rsp_data      (rsp_data),
    .done          (done),
    .done_abort    (done_abort),
    .fail_clr      (fail_clr),
    .fail_inc      (fail_inc)
  );

  xact_fail_cnt #(.W(LEN_W)) u_fail (
    .clk   (clk),
    .rst_n (srst_n),
    .clr   (fail_clr),
    .inc   (fail_inc),
    .count (done_nacks)
  );
endmodule

// File: tb/tb_i2c_xact_ctrl.sv
`timescale 1ns/1ps
module tb_i2c_xact_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_rep_start = 1'b0;
  logic        cfg_fold_en = 1'b0;
  logic [6:0]  cfg_fold_mask = 7'd0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'd0;
  logic [6:0]  req_dev = 7'd0;
  logic [31:0] req_addr = 32'd0;
  logic [2:0]  req_alen = 3'd0;
  logic [7:0]  req_len = 8'd0;
  logic        wr_valid = 1'b1;
  logic        wr_ready;
  logic [7:0]  wr_data = 8'hC0;
  logic        rd_valid;
  logic        rd_ready = 1'b1;
  logic [7:0]  rd_data;
  logic        cmd_valid;
  logic        cmd_ready = 1'b1;
  logic [1:0]  cmd_op;
  logic [7:0]  cmd_data;
  logic        cmd_nack;
  logic        rsp_valid = 1'b0;
  logic        rsp_nack = 1'b0;
  logic [7:0]  rsp_data = 8'd0;
  logic        done;
  logic        done_abort;
  logic [7:0]  done_nacks;

  i2c_xact_ctrl dut (.*);

  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  // engine model and logs
  int         n_cmd, n_rd, wr_idx, done_cnt;
  logic [1:0] lg_op   [64];
  logic [7:0] lg_data [64];
  logic       lg_nack [64];
  logic       nack_plan [64];
  logic [7:0] rd_got  [64];
  logic       got_abort;
  logic [7:0] got_nacks;
  bit         pend;
  int         pidx, pdly;
  // expected sequence
  int         n_exp;
  logic [1:0] ex_op   [64];
  logic [7:0] ex_data [64];
  logic       ex_nack [64];

  always @(posedge clk) begin
    #2;
    cyc++;
    cmd_ready = (cyc % 3) != 1;
    rd_ready  = (cyc % 4) != 2;
  end

  always @(negedge clk) begin
    rsp_valid = 1'b0;
    if (pend) begin
      if (pdly == 0) begin
        rsp_valid = 1'b1;
        rsp_nack  = nack_plan[pidx];
        rsp_data  = 8'h30 + 8'(pidx);
        pend      = 1'b0;
      end else pdly--;
    end
    if (cmd_valid && cmd_ready && n_cmd < 64) begin
      lg_op[n_cmd]   = cmd_op;
      lg_data[n_cmd] = cmd_data;
      lg_nack[n_cmd] = cmd_nack;
      pend = 1'b1; pidx = n_cmd; pdly = 1;
      n_cmd++;
    end
    if (wr_valid && wr_ready) begin
      wr_idx++;
      wr_data = 8'hC0 + 8'(wr_idx);
    end
    if (rd_valid && rd_ready && n_rd < 64) begin
      rd_got[n_rd] = rd_data;
      n_rd++;
    end
    if (done) begin
      done_cnt++;
      got_abort = done_abort;
      got_nacks = done_nacks;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_all();
    @(posedge clk);
    n_cmd = 0; n_rd = 0; n_exp = 0; wr_idx = 0; wr_data = 8'hC0;
    for (int i = 0; i < 64; i++) nack_plan[i] = 1'b0;
  endtask

  task automatic ex(input logic [1:0] op, input logic [7:0] d, input logic nk);
    ex_op[n_exp] = op; ex_data[n_exp] = d; ex_nack[n_exp] = nk; n_exp++;
  endtask

  task automatic run(input int kind, input logic [6:0] dev, input logic [31:0] addr,
                     input int alen, input int len, input bit rep, input bit fold,
                     input logic [6:0] mask);
    int start_cnt;
    start_cnt = done_cnt;
    @(negedge clk);
    cfg_rep_start = rep; cfg_fold_en = fold; cfg_fold_mask = mask;
    req_kind = 2'(kind); req_dev = dev; req_addr = addr;
    req_alen = 3'(alen); req_len = 8'(len);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int t = 0; t < 3000 && done_cnt == start_cnt; t++) @(negedge clk);
    check(done_cnt != start_cnt, "R12 completion seen", done_cnt - start_cnt, 1);
  endtask

  task automatic check_seq(input string tag);
    int bad;
    bad = -1;
    for (int i = 0; i < n_exp && i < n_cmd; i++)
      if (bad < 0 && (lg_op[i] != ex_op[i] ||
          ((ex_op[i] == 2'd2) && lg_data[i] != ex_data[i]) ||
          ((ex_op[i] == 2'd3) && lg_nack[i] != ex_nack[i])))
        bad = i;
    check(n_cmd == n_exp, {tag, " command count"}, n_cmd, n_exp);
    if (bad >= 0)
      check(1'b0, {tag, " command mismatch"},
            {lg_op[bad], lg_data[bad], 7'd0, lg_nack[bad]},
            {ex_op[bad], ex_data[bad], 7'd0, ex_nack[bad]});
    else
      check(1'b1, tag, 0, 0);
  endtask

  task automatic check_rd(input string tag);
    int k;
    k = 0;
    for (int i = 0; i < n_exp; i++) begin
      if (ex_op[i] == 2'd3) begin
        if (k < n_rd)
          check(rd_got[k] == 8'h30 + 8'(i), tag, rd_got[k], 8'h30 + 8'(i));
        k++;
      end
    end
    check(n_rd == k, {tag, " byte count"}, n_rd, k);
  endtask

  // scenarios
  task automatic t_reset();
    @(negedge clk);
    check(req_ready == 1'b1, "R12 req_ready after reset", req_ready, 1);
    check(cmd_valid == 1'b0 && rd_valid == 1'b0 && done == 1'b0,
          "R1 quiet after reset", {cmd_valid, rd_valid, done}, 0);
  endtask

  task automatic t_probe_present();
    clear_all();
    ex(0, 0, 0); ex(2, 8'hA0, 0); ex(1, 0, 0);
    run(0, 7'h50, 0, 0, 0, 0, 0, 0);
    check_seq("R2 probe present");
    check(got_abort == 1'b0, "R2 present status", got_abort, 0);
  endtask

  task automatic t_probe_absent();
    clear_all();
    nack_plan[1] = 1'b1;
    ex(0, 0, 0); ex(2, 8'hE6, 0); ex(1, 0, 0);
    run(0, 7'h73, 0, 0, 0, 0, 0, 0);
    check_seq("R2 probe absent");
    check(got_abort == 1'b1, "R2 absent status", got_abort, 1);
  endtask

  task automatic t_write_nacks();
    clear_all();
    nack_plan[4] = 1'b1; nack_plan[6] = 1'b1;
    ex(0, 0, 0); ex(2, 8'hA0, 0); ex(2, 8'h12, 0); ex(2, 8'h34, 0);
    ex(2, 8'hC0, 0); ex(2, 8'hC1, 0); ex(2, 8'hC2, 0); ex(1, 0, 0);
    run(2, 7'h50, 32'h1234, 2, 3, 0, 0, 0);
    check_seq("R3 write with data nacks");
    check(got_nacks == 8'd2, "R12 nack count", got_nacks, 2);
    check(got_abort == 1'b0, "R12 no abort on data nack", got_abort, 0);
  endtask

  task automatic t_write_alen4();
    clear_all();
    ex(0, 0, 0); ex(2, 8'h22, 0); ex(2, 8'h01, 0); ex(2, 8'h02, 0);
    ex(2, 8'h03, 0); ex(2, 8'h04, 0); ex(1, 0, 0);
    run(2, 7'h11, 32'h01020304, 4, 0, 0, 0, 0);
    check_seq("R3 four address bytes msb first");
    check(got_nacks == 8'd0, "R12 zero nacks", got_nacks, 0);
  endtask

  task automatic t_read_stop_start();
    clear_all();
    ex(0, 0, 0); ex(2, 8'hA0, 0); ex(2, 8'h07, 0); ex(1, 0, 0);
    ex(0, 0, 0); ex(2, 8'hA1, 0); ex(3, 0, 0); ex(3, 0, 1); ex(1, 0, 0);
    run(1, 7'h50, 32'h07, 1, 2, 0, 0, 0);
    check_seq("R4 read stop+start R7");
    check_rd("R7 read data");
    check(got_abort == 1'b0, "R4 status", got_abort, 0);
  endtask

  task automatic t_read_rep();
    clear_all();
    ex(0, 0, 0); ex(2, 8'hA0, 0); ex(2, 8'hBE, 0); ex(2, 8'hEF, 0);
    ex(0, 0, 0); ex(2, 8'hA1, 0); ex(3, 0, 1); ex(1, 0, 0);
    run(1, 7'h50, 32'hBEEF, 2, 1, 1, 0, 0);
    check_seq("R5 read repeated start");
    check_rd("R7 single byte read");
  endtask

  task automatic t_read_noaddr();
    clear_all();
    nack_plan[1] = 1'b1;
    ex(0, 0, 0); ex(2, 8'h91, 0); ex(3, 0, 0); ex(3, 0, 0); ex(3, 0, 1); ex(1, 0, 0);
    run(1, 7'h48, 32'hFF, 0, 3, 0, 0, 0);
    check_seq("R6 read without pointer phase");
    check_rd("R7 three byte read");
    check(got_abort == 1'b0, "R10 read address nack ignored", got_abort, 0);
  endtask

  task automatic t_dev_nack_read();
    clear_all();
    nack_plan[1] = 1'b1;
    ex(0, 0, 0); ex(2, 8'hA0, 0); ex(1, 0, 0);
    run(1, 7'h50, 32'h10, 1, 2, 0, 0, 0);
    check_seq("R8 device nack stops");
    check(got_abort == 1'b1, "R8 abort flag", got_abort, 1);
    check(n_rd == 0, "R8 no read data", n_rd, 0);
  endtask

  task automatic t_addr_nack();
    clear_all();
    nack_plan[3] = 1'b1;
    ex(0, 0, 0); ex(2, 8'hA0, 0); ex(2, 8'hAB, 0); ex(2, 8'hCD, 0); ex(1, 0, 0);
    run(2, 7'h50, 32'hABCDEF, 3, 2, 0, 0, 0);
    check_seq("R9 address nack stops");
    check(got_abort == 1'b1, "R9 abort flag", got_abort, 1);
  endtask

  task automatic t_fold();
    clear_all();
    ex(0, 0, 0); ex(2, 8'hA6, 0); ex(2, 8'h05, 0); ex(2, 8'hC0, 0); ex(1, 0, 0);
    run(2, 7'h50, 32'h0305, 1, 1, 0, 1, 7'h07);
    check_seq("R11 fold into device address");
    clear_all();
    ex(0, 0, 0); ex(2, 8'hA0, 0); ex(2, 8'h07, 0); ex(2, 8'h05, 0); ex(1, 0, 0);
    ex(0, 0, 0); ex(2, 8'hA1, 0); ex(3, 0, 1); ex(1, 0, 0);
    run(1, 7'h50, 32'h0705, 2, 1, 0, 1, 7'h07);
    check_seq("R11 nothing above full address length");
  endtask

  initial begin
    #(10 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    n_cmd = 0; n_rd = 0; wr_idx = 0; done_cnt = 0; pend = 1'b0;
    pidx = 0; pdly = 0; n_exp = 0; got_abort = 1'b0; got_nacks = 8'd0;
    for (int i = 0; i < 64; i++) nack_plan[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_probe_present();
    t_probe_absent();
    t_write_nacks();
    t_write_alen4();
    t_read_stop_start();
    t_read_rep();
    t_read_noaddr();
    t_dev_nack_read();
    t_addr_nack();
    t_fold();
    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule